// File: doc/BRIEF.md
# Adjacent Instruction Pair Fusion Detector

This decode-stage unit looks at a group of `N_SLOTS` instructions fetched in the same cycle and finds adjacent pairs that can be merged into one internal operation. Each slot carries a valid bit, a 32-bit instruction word (already in its full 32-bit encoding) and a flag that says whether the instruction was originally a 16-bit compressed one. When slot *i* and slot *i+1* form a recognised idiom, slot *i* leaves the unit with a nonzero fused-operation code and a length tag, and slot *i+1* leaves with its valid bit cleared. The fetch side can therefore still account for the removed instruction's address.

Recognised idioms are shift, mask and add sequences in which the second instruction consumes and overwrites the first one's result. Scanning runs from slot 0 upward and is greedy, so an instruction that has already been used as a second half never starts a new pair. All outputs are registered.

Top module: `fusion_detect`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `fuse_op_o` and `fuse_ofs_o` are all zero.
- R2: Outputs are registered. The result for the inputs present at a rising edge appears after that edge and is held until the next one.
- R3: When slot i fuses, `fuse_op_o[4i+:4]` is nonzero, `valid_o[i]` is 1 and `valid_o[i+1]` is 0. Every slot that does not fuse and is not consumed passes its valid bit through with op 0 and tag 0.
- R4: A left shift by 1, 2, 3 or 4 followed by `add` gives code 1, 2, 3 or 9 respectively. A logical right shift by 30, 31 or 32 followed by `add` gives code 10, 11 or 12 respectively. The `add` may read the shared register in either source position.
- R5: `slli` by 32 followed by `srli` by 31 gives code 6, and followed by `srli` by 30 gives code 7. `slli` by 48 followed by `srli` by 48 gives code 4, and followed by `srai` by 48 gives code 5. `srli` by 8 followed by `andi` with 255 gives code 8.
- R6: `andi` with 1 followed by `add` gives code 13, and followed by `addw` gives code 14. `andi` with -256 (imm 0xF00) followed by `or` gives code 15.
- R7: A pair fuses only when the second instruction writes the first one's destination register, reads that register, and that register is not x0. A shift amount or immediate outside the listed values prevents fusion.
- R8: Both slots must be valid. A consumed second half cannot start a pair, and the last slot never fuses.
- R9: The 2-bit tag of a fused slot is {second is 32-bit, first is 32-bit}, where `rvc_i`=1 means the instruction is 16-bit. Slots with code 0 have tag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | N_SLOTS | Per-slot valid |
| rvc_i | input | N_SLOTS | Per-slot 16-bit-origin flag |
| instr_i | input | 32*N_SLOTS | Instruction words, slot i at [32i+:32] |
| valid_o | output | N_SLOTS | Valid after removal of consumed slots |
| fuse_op_o | output | 4*N_SLOTS | Fused-operation code per slot, 0 = none |
| fuse_op_o | output | | (see above) |
| fuse_ofs_o | output | 2*N_SLOTS | Length tag per slot |

## Verification
Every output is due one rising edge after its inputs are presented, because there is a single register stage. The driver applies a group on a falling edge and queues the expected values. The monitor pops exactly one entry per rising edge and compares it half a phase later, so each comparison lands in the cycle that the registered result occupies. Groups are issued back to back, which also shows that no result leaks into a neighbouring cycle.

// File: rtl/fusion_pkg.sv
`timescale 1ns/1ps
package fusion_pkg;
  localparam int unsigned INSN_W = 32;
  localparam int unsigned OP_W   = 4;
  localparam int unsigned OFS_W  = 2;

  localparam logic [6:0] OPC_OPIMM = 7'h13;
  localparam logic [6:0] OPC_OP    = 7'h33;
  localparam logic [6:0] OPC_OP32  = 7'h3B;

  typedef enum logic [OP_W-1:0] {
    FOP_NONE    = 4'd0,
    FOP_SH1ADD  = 4'd1,
    FOP_SH2ADD  = 4'd2,
    FOP_SH3ADD  = 4'd3,
    FOP_ZEXTH   = 4'd4,
    FOP_SEXTH   = 4'd5,
    FOP_SZEWL1  = 4'd6,
    FOP_SZEWL2  = 4'd7,
    FOP_BYTE2   = 4'd8,
    FOP_SH4ADD  = 4'd9,
    FOP_SR30ADD = 4'd10,
    FOP_SR31ADD = 4'd11,
    FOP_SR32ADD = 4'd12,
    FOP_ODDADD  = 4'd13,
    FOP_ODDADDW = 4'd14,
    FOP_ORH48   = 4'd15
  } fuse_op_e;

  typedef struct packed {
    logic       slli;
    logic       srli;
    logic       srai;
    logic       andi;
    logic       add;
    logic       addw;
    logic       orr;
    logic [4:0] rd;
    logic [4:0] rs1;
    logic [4:0] rs2;
    logic [5:0] shamt;
    logic [11:0] imm;
  } insn_info_t;

  function automatic insn_info_t decode_insn(input logic [INSN_W-1:0] w);
    insn_info_t r;
    logic [6:0] opc;
    logic [2:0] f3;
    logic [6:0] f7;
    opc     = w[6:0];
    f3      = w[14:12];
    f7      = w[31:25];
    r.rd    = w[11:7];
    r.rs1   = w[19:15];
    r.rs2   = w[24:20];
    r.shamt = w[25:20];
    r.imm   = w[31:20];
    r.slli  = (opc == OPC_OPIMM) && (f3 == 3'b001) && (w[31:26] == 6'b000000);
    r.srli  = (opc == OPC_OPIMM) && (f3 == 3'b101) && (w[31:26] == 6'b000000);
    r.srai  = (opc == OPC_OPIMM) && (f3 == 3'b101) && (w[31:26] == 6'b010000);
    r.andi  = (opc == OPC_OPIMM) && (f3 == 3'b111);
    r.add   = (opc == OPC_OP)    && (f3 == 3'b000) && (f7 == 7'd0);
    r.addw  = (opc == OPC_OP32)  && (f3 == 3'b000) && (f7 == 7'd0);
    r.orr   = (opc == OPC_OP)    && (f3 == 3'b110) && (f7 == 7'd0);
    return r;
  endfunction
endpackage

// File: rtl/fusion_pair_match.sv
`timescale 1ns/1ps
module fusion_pair_match
  import fusion_pkg::*;
(
  input  logic [INSN_W-1:0] first_i,
  input  logic [INSN_W-1:0] second_i,
  output fuse_op_e          op_o
);
  insn_info_t a, b;
  logic tail_rr, tail_r1;

  assign a = decode_insn(first_i);
  assign b = decode_insn(second_i);

  // second overwrites first's result and consumes it
  assign tail_r1 = (b.rd == a.rd) && (a.rd != 5'd0) && (b.rs1 == a.rd);
  assign tail_rr = (b.rd == a.rd) && (a.rd != 5'd0) &&
                   ((b.rs1 == a.rd) || (b.rs2 == a.rd));

  always_comb begin
    op_o = FOP_NONE;
    if (a.slli && b.add && tail_rr) begin
      case (a.shamt)
        6'd1:    op_o = FOP_SH1ADD;
        6'd2:    op_o = FOP_SH2ADD;
        6'd3:    op_o = FOP_SH3ADD;
        6'd4:    op_o = FOP_SH4ADD;
        default: op_o = FOP_NONE;
      endcase
    end else if (a.srli && b.add && tail_rr) begin
      case (a.shamt)
        6'd30:   op_o = FOP_SR30ADD;
        6'd31:   op_o = FOP_SR31ADD;
        6'd32:   op_o = FOP_SR32ADD;
        default: op_o = FOP_NONE;
      endcase
    end else if (a.slli && (a.shamt == 6'd32) && b.srli && tail_r1) begin
      if (b.shamt == 6'd31)      op_o = FOP_SZEWL1;
      else if (b.shamt == 6'd30) op_o = FOP_SZEWL2;
    end else if (a.slli && (a.shamt == 6'd48) && (b.shamt == 6'd48) && tail_r1) begin
      if (b.srli)      op_o = FOP_ZEXTH;
      else if (b.srai) op_o = FOP_SEXTH;
    end else if (a.srli && (a.shamt == 6'd8) && b.andi && (b.imm == 12'h0FF) && tail_r1) begin
      op_o = FOP_BYTE2;
    end else if (a.andi && (a.imm == 12'h001) && tail_rr) begin
      if (b.add)       op_o = FOP_ODDADD;
      else if (b.addw) op_o = FOP_ODDADDW;
    end else if (a.andi && (a.imm == 12'hF00) && b.orr && tail_rr) begin
      op_o = FOP_ORH48;
    end
  end
endmodule

// File: rtl/fusion_select.sv
`timescale 1ns/1ps
module fusion_select
  import fusion_pkg::*;
#(
  parameter int unsigned N_SLOTS = 4
) (
  input  logic [N_SLOTS-1:0]            valid_i,
  input  logic [N_SLOTS-1:0]            rvc_i,
  input  logic [(N_SLOTS-1)*OP_W-1:0]   pair_op_i,
  output logic [N_SLOTS-1:0]            valid_o,
  output logic [N_SLOTS*OP_W-1:0]       op_o,
  output logic [N_SLOTS*OFS_W-1:0]      ofs_o
);
  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    logic hd;
    if (i < N_SLOTS-1) begin : g_pair
      logic cand;
      assign cand = valid_i[i] & valid_i[i+1] & (pair_op_i[i*OP_W +: OP_W] != '0);
      if (i == 0) begin : g_first
        assign hd = cand;
      end else begin : g_rest
        assign hd = cand & ~g_slot[i-1].hd;
      end
      assign op_o[i*OP_W +: OP_W]    = hd ? pair_op_i[i*OP_W +: OP_W] : '0;
      assign ofs_o[i*OFS_W +: OFS_W] = hd ? {~rvc_i[i+1], ~rvc_i[i]} : '0;
    end else begin : g_last
      assign hd = 1'b0;
      assign op_o[i*OP_W +: OP_W]    = '0;
      assign ofs_o[i*OFS_W +: OFS_W] = '0;
    end
    if (i == 0) begin : g_v0
      assign valid_o[i] = valid_i[i];
    end else begin : g_vn
      assign valid_o[i] = valid_i[i] & ~g_slot[i-1].hd;
    end
  end
endmodule

// File: rtl/fusion_detect.sv
`timescale 1ns/1ps
module fusion_detect
  import fusion_pkg::*;
#(
  parameter int unsigned N_SLOTS = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_SLOTS-1:0]          valid_i,
  input  logic [N_SLOTS-1:0]          rvc_i,
  input  logic [N_SLOTS*INSN_W-1:0]   instr_i,
  output logic [N_SLOTS-1:0]          valid_o,
  output logic [N_SLOTS*OP_W-1:0]     fuse_op_o,
  output logic [N_SLOTS*OFS_W-1:0]    fuse_ofs_o
);
  localparam int unsigned N_PAIRS = N_SLOTS - 1;

  logic [N_PAIRS*OP_W-1:0]   pair_op;
  logic [N_SLOTS-1:0]        valid_d;
  logic [N_SLOTS*OP_W-1:0]   op_d;
  logic [N_SLOTS*OFS_W-1:0]  ofs_d;

  for (genvar p = 0; p < N_PAIRS; p++) begin : g_match
    fuse_op_e op;
    fusion_pair_match u_match (
      .first_i  (instr_i[p*INSN_W     +: INSN_W]),
      .second_i (instr_i[(p+1)*INSN_W +: INSN_W]),
      .op_o     (op)
    );
    assign pair_op[p*OP_W +: OP_W] = op;
  end

  fusion_select #(.N_SLOTS(N_SLOTS)) u_select (
    .valid_i   (valid_i),
    .rvc_i     (rvc_i),
    .pair_op_i (pair_op),
    .valid_o   (valid_d),
    .op_o      (op_d),
    .ofs_o     (ofs_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= '0;
      fuse_op_o  <= '0;
      fuse_ofs_o <= '0;
    end else begin
      valid_o    <= valid_d;
      fuse_op_o  <= op_d;
      fuse_ofs_o <= ofs_d;
    end
  end
endmodule

// File: rtl/fusion_detect_chk.sv
`timescale 1ns/1ps
module fusion_detect_chk #(
  parameter int unsigned N_SLOTS = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [N_SLOTS-1:0]     valid_i,
  input logic [N_SLOTS-1:0]     valid_o,
  input logic [N_SLOTS*4-1:0]   fuse_op_o,
  input logic [N_SLOTS*2-1:0]   fuse_ofs_o
);
  // R2
  valid_subset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o & ~$past(valid_i)) == '0);

  // R8
  last_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fuse_op_o[(N_SLOTS-1)*4 +: 4] == 4'd0);

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_chk
    // R9
    ofs_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fuse_op_o[i*4 +: 4] == 4'd0) |-> (fuse_ofs_o[i*2 +: 2] == 2'd0));
    if (i < N_SLOTS-1) begin : g_pair
      // R3
      fused_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fuse_op_o[i*4 +: 4] != 4'd0) |-> (valid_o[i] && !valid_o[i+1]));
      // R8
      no_adjacent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fuse_op_o[i*4 +: 4] != 4'd0) |-> (fuse_op_o[(i+1)*4 +: 4] == 4'd0));
    end
  end
endmodule

bind fusion_detect fusion_detect_chk #(.N_SLOTS(N_SLOTS)) u_fusion_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .valid_o    (valid_o),
  .fuse_op_o  (fuse_op_o),
  .fuse_ofs_o (fuse_ofs_o)
);

// File: tb/fusion_detect_tb.sv
`timescale 1ns/1ps
module fusion_detect_tb;
  localparam int N = 4;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic [N-1:0]    valid_i = '0;
  logic [N-1:0]    rvc_i = '0;
  logic [N*32-1:0] instr_i = '0;
  logic [N-1:0]    valid_o;
  logic [N*4-1:0]  fuse_op_o;
  logic [N*2-1:0]  fuse_ofs_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    logic [3:0]  v;
    logic [15:0] op;
    logic [7:0]  ofs;
    string       req;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  fusion_detect #(.N_SLOTS(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .rvc_i(rvc_i),
    .instr_i(instr_i), .valid_o(valid_o), .fuse_op_o(fuse_op_o),
    .fuse_ofs_o(fuse_ofs_o)
  );

  function automatic logic [31:0] slli(input int rd, input int rs, input int sh);
    return {6'b000000, 6'(sh), 5'(rs), 3'b001, 5'(rd), 7'h13};
  endfunction
  function automatic logic [31:0] srli(input int rd, input int rs, input int sh);
    return {6'b000000, 6'(sh), 5'(rs), 3'b101, 5'(rd), 7'h13};
  endfunction
  function automatic logic [31:0] srai(input int rd, input int rs, input int sh);
    return {6'b010000, 6'(sh), 5'(rs), 3'b101, 5'(rd), 7'h13};
  endfunction
  function automatic logic [31:0] andi(input int rd, input int rs, input logic [11:0] imm);
    return {imm, 5'(rs), 3'b111, 5'(rd), 7'h13};
  endfunction
  function automatic logic [31:0] add(input int rd, input int a, input int b);
    return {7'd0, 5'(b), 5'(a), 3'b000, 5'(rd), 7'h33};
  endfunction
  function automatic logic [31:0] addw(input int rd, input int a, input int b);
    return {7'd0, 5'(b), 5'(a), 3'b000, 5'(rd), 7'h3B};
  endfunction
  function automatic logic [31:0] orr(input int rd, input int a, input int b);
    return {7'd0, 5'(b), 5'(a), 3'b110, 5'(rd), 7'h33};
  endfunction
  localparam logic [31:0] NOP = 32'h0000_0013;

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // driver: apply on falling edge, queue what the next rising edge must produce
  task automatic drive(input logic [3:0] v, input logic [31:0] w0, input logic [31:0] w1,
                       input logic [31:0] w2, input logic [31:0] w3, input logic [3:0] c,
                       input logic [3:0] ev, input logic [15:0] eo, input logic [7:0] ef,
                       input string req);
    exp_t e;
    @(negedge clk);
    valid_i = v;
    instr_i = {w3, w2, w1, w0};
    rvc_i   = c;
    e.v = ev; e.op = eo; e.ofs = ef; e.req = req;
    q.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.req, "valid", 16'(valid_o), 16'(e.v));
        check(e.req, "op", fuse_op_o, e.op);
        check(e.req, "ofs", 16'(fuse_ofs_o), 16'(e.ofs));
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    valid_i = '1;
    instr_i = {NOP, NOP, add(5, 5, 7), slli(5, 6, 1)};
    @(negedge clk);
    check("R1", "valid", 16'(valid_o), 16'h0);
    check("R1", "op", fuse_op_o, 16'h0);
    check("R1", "ofs", 16'(fuse_ofs_o), 16'h0);
    valid_i = '0;
    rst_ni = 1'b1;
    @(negedge clk);

    // R3 R4 sh1add in slot0
    drive(4'b1111, slli(5,6,1), add(5,5,7), NOP, NOP, 4'b0000, 4'b1101, 16'h0001, 8'h03, "R4");
    // R4 rs2 position + R5 byte2
    drive(4'b1111, slli(5,6,3), add(5,7,5), srli(8,9,8), andi(8,8,12'h0FF), 4'b0000,
          4'b0101, 16'h0803, 8'h33, "R4");
    // R9 first compressed, R5 szewl1
    drive(4'b1111, NOP, slli(10,11,32), srli(10,10,31), NOP, 4'b0010,
          4'b1011, 16'h0060, 8'h08, "R9");
    // R5 sexth / zexth, mixed lengths
    drive(4'b1111, slli(12,13,48), srai(12,12,48), slli(14,15,48), srli(14,14,48), 4'b1001,
          4'b0101, 16'h0405, 8'h12, "R5");
    drive(4'b1111, slli(5,6,32), srli(5,5,30), slli(7,8,2), add(7,7,9), 4'b0000,
          4'b0101, 16'h0207, 8'h33, "R5");
    drive(4'b1111, slli(5,6,4), add(5,5,6), srli(9,10,30), add(9,9,11), 4'b0000,
          4'b0101, 16'h0A09, 8'h33, "R4");
    drive(4'b1111, srli(5,6,31), add(5,5,7), srli(8,9,32), add(8,3,8), 4'b0000,
          4'b0101, 16'h0C0B, 8'h33, "R4");
    // R6
    drive(4'b1111, andi(5,6,12'h001), add(5,5,7), andi(8,9,12'h001), addw(8,8,1), 4'b0000,
          4'b0101, 16'h0E0D, 8'h33, "R6");
    drive(4'b1111, andi(5,6,12'hF00), orr(5,7,5), NOP, NOP, 4'b0000,
          4'b1101, 16'h000F, 8'h03, "R6");
    // R7 x0 destination, different destination
    drive(4'b1111, slli(0,6,1), add(0,0,7), slli(5,6,1), add(8,5,7), 4'b0000,
          4'b1111, 16'h0000, 8'h00, "R7");
    // R7 second does not read, shift amount out of list
    drive(4'b1111, slli(5,6,1), add(5,7,8), srli(5,6,29), add(5,5,7), 4'b0000,
          4'b1111, 16'h0000, 8'h00, "R7");
    drive(4'b1111, slli(5,6,32), srli(5,5,32), srli(8,9,8), andi(8,8,12'h07F), 4'b0000,
          4'b1111, 16'h0000, 8'h00, "R7");
    // R8 greedy: slot1 consumed, cannot start sr31add with slot2
    drive(4'b1111, slli(5,6,32), srli(5,5,31), add(5,5,7), NOP, 4'b0000,
          4'b1101, 16'h0006, 8'h03, "R8");
    // R8 with slot0 invalid, slot1-2 pair forms
    drive(4'b1110, slli(5,6,32), srli(5,5,31), add(5,5,7), NOP, 4'b0000,
          4'b1010, 16'h00B0, 8'h0C, "R8");
    // R8 second half invalid
    drive(4'b1101, slli(5,6,1), add(5,5,7), NOP, NOP, 4'b0000,
          4'b1101, 16'h0000, 8'h00, "R8");
    // R8 last slot
    drive(4'b1111, NOP, NOP, NOP, slli(5,6,1), 4'b1111,
          4'b1111, 16'h0000, 8'h00, "R8");
    // R2 idle group clears outputs
    drive(4'b0000, slli(5,6,1), add(5,5,7), NOP, NOP, 4'b0000,
          4'b0000, 16'h0000, 8'h00, "R2");
    drive(4'b1111, slli(5,6,2), add(5,5,7), NOP, NOP, 4'b0011,
          4'b1101, 16'h0002, 8'h00, "R2");

    @(negedge clk);
    valid_i = '0;
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL R2 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule